// File: doc/BRIEF.md
# Command-Driven I2C Configuration Slave

This block is the two-wire configuration port of a three-channel video conditioning front end. A bus master addresses the slave and sends single command bytes. Each command sets or clears one control bit, loads the cutoff-frequency register from the byte that follows, restores the control defaults, or arms a one-byte readback. There is no register pointer. The two 8-bit registers are brought out as plain outputs and steer the analog filter, clamp and sync circuitry elsewhere on the chip.

SCL and SDA are sampled on a system clock that runs at least eight times faster than SCL. Both pass through a two-flop synchronizer and are then edge-detected. SDA is driven as an open-drain pin: the slave only pulls it low. Writes take effect when the eighth bit of a byte arrives, so a STOP that cuts a byte short leaves every register untouched. A read must first be armed by a command byte. The master then issues a repeated START with the read address, and the slave returns one byte.

Control register bits: bit 0 = powered (1) or powered down (0); bit 1 = low clamp level; bit 2 = composite input; bit 3 = external sync; bit 4 = negative sync polarity; bit 5 = filter bypass; bits 7:6 always 0.

Top module: `cfg_i2c_slave`

## Requirements
- R1: Reset sets the control register to 0x03 and the frequency register to 0x00, and leaves SDA released.
- R2: The slave answers only the 7-bit address 1,0,0,1,0 followed by addr_pins[1:0], sent MSB first, with the R/W bit after it (0 = write, 1 = read). It ACKs by holding SDA low through the ninth clock. On a mismatch, including the general call address 0x00, it NACKs and ignores the bus until the next START.
- R3: Command 0x12 loads the next data byte into the frequency register. The load happens when the eighth bit of that data byte arrives.
- R4: Each of these commands sets or clears one control bit and leaves the frequency register unchanged: 0x13 sets bit 0, 0x14 clears bit 0, 0x11 sets bit 1, 0x10 clears bit 1, 0x09 sets bit 2, 0x08 clears bit 2, 0x0B sets bit 3, 0x0A clears bit 3, 0x0D sets bit 4, 0x0C clears bit 4, 0x0E sets bit 5, 0x0F clears bit 5.
- R5: Command 0x15 restores the control register to 0x03 and leaves the frequency register unchanged.
- R6: Any undefined command byte is NACKed and changes no state. The slave then ignores the bus until the next START.
- R7: Command 0x16 arms a read of the control register and 0x17 arms a read of the frequency register. After a repeated START and the read address, the slave ACKs and drives the selected byte MSB first, then releases SDA for the master's ninth clock. A read address with nothing armed is NACKed.
- R8: A STOP at any point ends the transfer. A partly received byte updates nothing, and an armed read is cancelled.
- R9: A STOP that falls in the same SCL-high pulse as a START is not treated as a STOP.
- R10: Several command bytes may follow one address. Write sequences may be chained with or without a repeated START between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| addr_pins | input | 2 | Two low bits of the slave address |
| sda_oe | output | 1 | Pull SDA low when 1 |
| ctrl_q | output | 8 | Control register |
| freq_q | output | 8 | Cutoff-frequency register |

## Verification
The bench targets a STOP that arrives mid-byte. A design that commits on partial data would load a truncated value into the frequency register. It also sends a START and a STOP inside one SCL-high pulse. A design that honours that STOP would drop the address that follows and NACK it. Other checks cover an armed read cancelled by STOP, an undefined opcode followed by a valid one, a mismatched address, and the general call address. A design that kept listening after any of these would change control bits it should leave alone. Finally, the bench confirms that the control reset command leaves the frequency register unchanged, and that a read returns the register selected by the arming command.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [4:0] DEV_ID       = 5'b10010,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] CTRL_DEFAULT = 8'h03,
  parameter logic [7:0] FREQ_DEFAULT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_pins,
  output logic       sda_oe,
  output logic [7:0] ctrl_q,
  output logic [7:0] freq_q
);
  localparam logic [7:0] OP_FREQ    = 8'h12;
  localparam logic [7:0] OP_CTRL_RST = 8'h15;
  localparam logic [7:0] OP_RD_CTRL = 8'h16;
  localparam logic [7:0] OP_RD_FREQ = 8'h17;
  localparam logic [1:0] SEL_NONE = 2'd0, SEL_CTRL = 2'd1, SEL_FREQ = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_TX} st_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} kind_t;

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;
  wire scl_s = scl_sr[SYNC_STAGES-1];
  wire sda_s = sda_sr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1; sda_sr <= '1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  st_t         st;
  kind_t       kind;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic        ack, go_tx, start_hi;
  logic [1:0]  rd_sel;

  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s & ~start_hi;
  wire [7:0] rx_byte = {shreg[6:0], sda_s};
  wire [7:0] tx_src  = (rd_sel == SEL_FREQ) ? freq_q : ctrl_q;

  logic       cmd_ok;
  logic [7:0] ctrl_nx;
  always_comb begin
    cmd_ok  = 1'b1;
    ctrl_nx = ctrl_q;
    case (rx_byte)
      8'h13: ctrl_nx[0] = 1'b1;
      8'h14: ctrl_nx[0] = 1'b0;
      8'h11: ctrl_nx[1] = 1'b1;
      8'h10: ctrl_nx[1] = 1'b0;
      8'h09: ctrl_nx[2] = 1'b1;
      8'h08: ctrl_nx[2] = 1'b0;
      8'h0B: ctrl_nx[3] = 1'b1;
      8'h0A: ctrl_nx[3] = 1'b0;
      8'h0D: ctrl_nx[4] = 1'b1;
      8'h0C: ctrl_nx[4] = 1'b0;
      8'h0E: ctrl_nx[5] = 1'b1;
      8'h0F: ctrl_nx[5] = 1'b0;
      OP_CTRL_RST: ctrl_nx = CTRL_DEFAULT;
      OP_FREQ, OP_RD_CTRL, OP_RD_FREQ: ;
      default: cmd_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; bitcnt <= '0; shreg <= '0;
      ack <= 1'b0; go_tx <= 1'b0; start_hi <= 1'b0; rd_sel <= SEL_NONE;
      sda_oe <= 1'b0; ctrl_q <= CTRL_DEFAULT; freq_q <= FREQ_DEFAULT;
    end else if (start_det) begin
      st <= S_RX; kind <= K_ADDR; bitcnt <= '0; sda_oe <= 1'b0; start_hi <= 1'b1;
    end else if (stop_det) begin
      st <= S_IDLE; rd_sel <= SEL_NONE; sda_oe <= 1'b0;
    end else begin
      if (scl_fall) start_hi <= 1'b0;
      case (st)
        S_RX:
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7)
              case (kind)
                K_ADDR:
                  if (rx_byte[7:1] == {DEV_ID, addr_pins}) begin
                    ack   <= rx_byte[0] ? (rd_sel != SEL_NONE) : 1'b1;
                    go_tx <= rx_byte[0];
                    if (!rx_byte[0]) kind <= K_CMD;
                  end else begin
                    ack <= 1'b0; go_tx <= 1'b0;
                  end
                K_CMD: begin
                  ack <= cmd_ok; go_tx <= 1'b0;
                  if (cmd_ok) begin
                    ctrl_q <= ctrl_nx;
                    if (rx_byte == OP_FREQ) kind <= K_DATA;
                    rd_sel <= (rx_byte == OP_RD_CTRL) ? SEL_CTRL :
                              (rx_byte == OP_RD_FREQ) ? SEL_FREQ : SEL_NONE;
                  end
                end
                default: begin
                  freq_q <= rx_byte; ack <= 1'b1; go_tx <= 1'b0; kind <= K_CMD;
                end
              endcase
          end else if (scl_fall && bitcnt == 4'd8) begin
            sda_oe <= ack;
            bitcnt <= 4'd9;
          end else if (scl_fall && bitcnt == 4'd9) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            if (!ack) st <= S_IDLE;
            else if (go_tx) begin
              st     <= S_TX;
              shreg  <= tx_src;
              sda_oe <= ~tx_src[7];
            end
          end
        S_TX:
          if (scl_rise && bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
              shreg  <= shreg << 1;
              sda_oe <= ~shreg[6];
            end else if (bitcnt == 4'd8) sda_oe <= 1'b0;
            else if (bitcnt == 4'd9) begin
              st <= S_IDLE; rd_sel <= SEL_NONE;
            end
          end
        default: ;
      endcase
    end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);
  // R7
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);
  // R3
  freq_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_q != $past(freq_q)) |-> $past(st == S_RX && kind == K_DATA && scl_rise));
  // R8
  stop_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && rd_sel == SEL_NONE));
  // R4
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:6] == 2'b00);
endmodule

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] pins = 2'b01;
  logic sda_oe;
  logic [7:0] ctrl_q, freq_q;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  logic cmp_en = 1'b0;
  logic [7:0] exp_ctrl = 8'h03, exp_freq = 8'h00;

  always #5 clk = ~clk;

  cfg_i2c_slave i_cfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_pins(pins),
    .sda_oe(sda_oe), .ctrl_q(ctrl_q), .freq_q(freq_q));

  always @(negedge clk) if (cmp_en) begin
    checks++;
    if (ctrl_q !== exp_ctrl || freq_q !== exp_freq) begin
      errors++;
      $display("FAIL R4/R3 model ctrl %h freq %h expected %h %h", ctrl_q, freq_q, exp_ctrl, exp_freq);
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hp(); repeat (8) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp(); hp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic acked);
    acked = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1;
      if (i == 0) cmp_en = 1'b0;
      hp(); scl_m = 1'b0;
    end
    if (n == 8) begin
      sda_m = 1'b1; hp(); scl_m = 1'b1;
      repeat (4) @(negedge clk);
      acked = !sda_line;
      repeat (4) @(negedge clk);
      scl_m = 1'b0;
    end
  endtask

  // mode 0: no model change, 1: command, 2: frequency data
  task automatic xfer(input logic [7:0] b, input logic exp_ack, input string tag, input int mode);
    logic a;
    send_bits(b, 8, a);
    checks++;
    if (a !== exp_ack) begin
      errors++;
      $display("FAIL %s ack for %h got %0d expected %0d", tag, b, a, exp_ack);
    end
    if (exp_ack && mode == 2) exp_freq = b;
    if (exp_ack && mode == 1)
      case (b)
        8'h13: exp_ctrl[0] = 1'b1;  8'h14: exp_ctrl[0] = 1'b0;
        8'h11: exp_ctrl[1] = 1'b1;  8'h10: exp_ctrl[1] = 1'b0;
        8'h09: exp_ctrl[2] = 1'b1;  8'h08: exp_ctrl[2] = 1'b0;
        8'h0B: exp_ctrl[3] = 1'b1;  8'h0A: exp_ctrl[3] = 1'b0;
        8'h0D: exp_ctrl[4] = 1'b1;  8'h0C: exp_ctrl[4] = 1'b0;
        8'h0E: exp_ctrl[5] = 1'b1;  8'h0F: exp_ctrl[5] = 1'b0;
        8'h15: exp_ctrl = 8'h03;
        default: ;
      endcase
    cmp_en = 1'b1;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1;
      repeat (4) @(negedge clk);
      b[i] = sda_line;
      repeat (4) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = !mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  function automatic logic [7:0] aw(); return {5'b10010, pins, 1'b0}; endfunction
  function automatic logic [7:0] ar(); return {5'b10010, pins, 1'b1}; endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    logic dummy;
    repeat (3) @(negedge clk);
    // R1 reset state
    check8("R1 ctrl", ctrl_q, 8'h03);
    check8("R1 freq", freq_q, 8'h00);
    check8("R1 sda", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R2 R3 frequency load
    bus_start(); xfer(aw(), 1, "R2", 0); xfer(8'h12, 1, "R3", 1); xfer(8'h5A, 1, "R3", 2); bus_stop();
    check8("R3 freq", freq_q, 8'h5A);

    // R4 R10 chained commands with and without Sr
    bus_start(); xfer(aw(), 1, "R2", 0);
    xfer(8'h0E, 1, "R4", 1); xfer(8'h09, 1, "R4", 1); xfer(8'h0B, 1, "R4", 1);
    xfer(8'h0D, 1, "R4", 1); xfer(8'h10, 1, "R10", 1);
    bus_start(); xfer(aw(), 1, "R10", 0); xfer(8'h14, 1, "R4", 1); bus_stop();
    check8("R4 ctrl set", ctrl_q, 8'h3C);
    bus_start(); xfer(aw(), 1, "R2", 0);
    xfer(8'h13, 1, "R4", 1); xfer(8'h0F, 1, "R4", 1); xfer(8'h08, 1, "R4", 1);
    xfer(8'h0A, 1, "R4", 1); xfer(8'h0C, 1, "R4", 1); xfer(8'h11, 1, "R4", 1); bus_stop();
    check8("R4 ctrl clear", ctrl_q, 8'h03);
    check8("R4 wake keeps freq", freq_q, 8'h5A);

    // R7 armed reads
    bus_start(); xfer(aw(), 1, "R7", 0); xfer(8'h17, 1, "R7", 1);
    bus_start(); xfer(ar(), 1, "R7", 0); recv_byte(rb, 1'b0); bus_stop();
    check8("R7 read freq", rb, 8'h5A);
    bus_start(); xfer(aw(), 1, "R7", 0); xfer(8'h0E, 1, "R7", 1); xfer(8'h16, 1, "R7", 1);
    bus_start(); xfer(ar(), 1, "R7", 0); recv_byte(rb, 1'b0); bus_stop();
    check8("R7 read ctrl", rb, 8'h23);
    bus_start(); xfer(ar(), 0, "R7 unarmed", 0); bus_stop();

    // R8 armed read cancelled by STOP
    bus_start(); xfer(aw(), 1, "R8", 0); xfer(8'h16, 1, "R8", 1); bus_stop();
    bus_start(); xfer(ar(), 0, "R8 cancel", 0); bus_stop();

    // R6 undefined opcode, then the bus is ignored
    bus_start(); xfer(aw(), 1, "R6", 0); xfer(8'h55, 0, "R6", 1); xfer(8'h0F, 0, "R6", 0); bus_stop();
    check8("R6 ctrl", ctrl_q, 8'h23);

    // R2 mismatch and general call
    bus_start(); xfer({5'b10010, ~pins, 1'b0}, 0, "R2 mismatch", 0); xfer(8'h0F, 0, "R2", 0); bus_stop();
    bus_start(); xfer(8'h00, 0, "R2 general call", 0); bus_stop();
    check8("R2 ctrl", ctrl_q, 8'h23);

    // R8 early STOP discards partial bytes
    bus_start(); xfer(aw(), 1, "R8", 0); xfer(8'h12, 1, "R8", 1);
    send_bits(8'hFF, 5, dummy); bus_stop();
    check8("R8 freq", freq_q, 8'h5A);
    bus_start(); xfer(aw(), 1, "R8", 0); send_bits(8'h0F, 7, dummy); bus_stop();
    check8("R8 ctrl", ctrl_q, 8'h23);

    // R5 control reset leaves frequency
    bus_start(); xfer(aw(), 1, "R5", 0); xfer(8'h12, 1, "R5", 1); xfer(8'hC4, 1, "R5", 2);
    xfer(8'h15, 1, "R5", 1); bus_stop();
    check8("R5 ctrl", ctrl_q, 8'h03);
    check8("R5 freq", freq_q, 8'hC4);

    // R9 START and STOP in one SCL-high pulse
    sda_m = 1'b0; repeat (4) @(negedge clk); sda_m = 1'b1; repeat (4) @(negedge clk);
    scl_m = 1'b0; hp();
    xfer(aw(), 1, "R9", 0); xfer(8'h0E, 1, "R9", 1); bus_stop();
    check8("R9 ctrl", ctrl_q, 8'h23);

    // R2 address pins
    pins = 2'b10;
    bus_start(); xfer(aw(), 1, "R2 pins", 0); xfer(8'h12, 1, "R3", 1); xfer(8'h33, 1, "R3", 2); bus_stop();
    check8("R2 pins freq", freq_q, 8'h33);

    cmp_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule